// File: doc/BRIEF.md
# Dual ARINC 429 Serial Word Receiver

This block takes two independent ARINC 429-style serial lines and turns each into a stored parallel word that a host reads over a 16-bit bus. Both channels run from one sampling clock at ten times the bit rate. Each clock is one sample. Each channel decodes the two-wire line state, slices bits by majority vote and frames a word when the line goes quiet. It then checks the bit count and parity, and can filter the word on its source/destination bits. An accepted word is stored and the channel raises its ready flag.

The host pulls a word out as two halves. It picks a channel with `rd_en` and a half with `rd_sel`, and reads `rd_data` in the same cycle. The read side has no back-pressure. A stored word stays until a complete new word replaces it, and the ready flag drops once both halves have been read. A self-test mode routes an internal transmitter pair into both channels, true into channel 0 and swapped (inverted) into channel 1, and the line pins are then ignored.

Top module: `dual_a429_rx`

## Requirements
- R1: While `rst_n` is low, and after it is released, both `ready` bits are 0 and `rd_data` is 0 while `rd_en` is 0.
- R2: Line code: A=1,B=0 is a one, A=0,B=1 is a zero, and A=B is null. Bits are sent first to last, each with 5 active samples and then 5 null samples. A run of at least 20 null samples ends a word. In 32-bit mode, a word of 32 bits sets that channel's `ready`. Half 0 is {bits 15..9, status, bits 8..1}, so bit 1 is at `rd_data[0]`. Half 1 is bits 31..16.
- R3: With `cfg_len32`=0 a 25-bit word is accepted: data bits 1..24, parity bit 25, and bits 25..31 read as 0.
- R4: The status bit at `rd_data[8]` of half 0 is 1 when the received word, including its parity bit, has an even number of ones, and 0 when the number is odd.
- R5: With `cfg_sd_en[c]`=1, a word is accepted only if bit 9 equals `cfg_sd_y[c]` and bit 10 equals `cfg_sd_x[c]`. Otherwise it is dropped and `ready` stays 0.
- R6: With `cfg_sd_en[c]`=0, the values of bits 9 and 10 have no effect on acceptance.
- R7: A word whose bit count differs from the configured length (25 or 32) is discarded.
- R8: `ready[c]` stays 1 after only one half has been read. It clears in the cycle after the second distinct half of channel c has been read.
- R9: A bit is the majority of samples 1..3 after the null-to-active edge. A single flipped sample inside that window does not change the bit.
- R10: With `cfg_selftest_n`=0, channel 0 receives the (`tx_a`,`tx_b`) pair and channel 1 receives it swapped, which inverts every bit. The line inputs have no effect.
- R11: The two channels frame, filter and flag their words independently of each other.
- R12: A word that is still being received does not change the stored word. Reads during reception return the previous word.
- R13: `rd_en[0]` selects channel 0 and takes priority when both bits are set. `rd_en`=2'b10 selects channel 1. A read counts only for the channel that drives the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, ten times the bit rate |
| rst_n | input | 1 | Active-low master reset |
| line_a | input | 2 | Line A wire per channel |
| line_b | input | 2 | Line B wire per channel |
| tx_a | input | 1 | Internal transmitter A wire for self-test |
| tx_b | input | 1 | Internal transmitter B wire for self-test |
| cfg_len32 | input | 1 | 1: 32-bit words, 0: 25-bit words |
| cfg_selftest_n | input | 1 | 0: loop the transmitter into both channels |
| cfg_sd_en | input | 2 | Per-channel source/destination filter enable |
| cfg_sd_x | input | 2 | Expected value of bit 10 per channel |
| cfg_sd_y | input | 2 | Expected value of bit 9 per channel |
| rd_sel | input | 1 | Half select: 0 low half, 1 high half |
| rd_en | input | 2 | Per-channel bus enable |
| rd_data | output | 16 | Selected half of the stored word |
| ready | output | 2 | Per-channel word-waiting flag |

## Verification
The bench sends words that are one bit short, and 32-bit words while in 25-bit mode. A framer that only counted up to the expected length would accept these truncated or overlong words. It sends filter-mismatched words to a filtered channel and an unfiltered channel at the same time. Swapped X/Y compares, or a filter applied with the enable off, show up as a wrong ready flag on one side. It flips one mid-window sample, which a single-sample slicer would turn into a wrong bit. It also reads a stored word while its replacement is half received, which exposes a design that overwrites on every bit instead of at word end, or clears the flag after a single half.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  parameter int unsigned WORD_BITS = 32;
  parameter int unsigned HALF_BITS = 16;

  typedef enum logic [1:0] {
    SYM_NULL = 2'd0,
    SYM_ZERO = 2'd1,
    SYM_ONE  = 2'd2
  } sym_e;

  typedef struct packed {
    logic                 status;
    logic [WORD_BITS-2:0] data;
  } rx_word_t;
endpackage

// File: rtl/a429_line_front.sv
module a429_line_front
  import a429_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wire_a,
  input  logic wire_b,
  output sym_e sym
);
  logic [SYNC_STAGES-1:0] sa_q, sb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q <= '0;
      sb_q <= '0;
    end else begin
      sa_q <= {sa_q[SYNC_STAGES-2:0], wire_a};
      sb_q <= {sb_q[SYNC_STAGES-2:0], wire_b};
    end
  end

  always_comb begin
    unique case ({sa_q[SYNC_STAGES-1], sb_q[SYNC_STAGES-1]})
      2'b10:   sym = SYM_ONE;
      2'b01:   sym = SYM_ZERO;
      default: sym = SYM_NULL;
    endcase
  end
endmodule

// File: rtl/a429_bit_slicer.sv
module a429_bit_slicer
  import a429_rx_pkg::*;
#(
  parameter int unsigned OSR = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  sym_e sym,
  output logic bit_vld,
  output logic bit_val,
  output logic gap
);
  localparam int unsigned WIN_LO   = OSR / 4 - 1;
  localparam int unsigned WIN_HI   = OSR / 4 + 1;
  localparam int unsigned WIN_N    = WIN_HI - WIN_LO + 1;
  localparam int unsigned MAJ      = WIN_N / 2 + 1;
  localparam int unsigned NULL_END = 2 * OSR;
  localparam int unsigned PW       = $clog2(OSR);
  localparam int unsigned NW       = $clog2(NULL_END + 1);
  localparam int unsigned VW       = $clog2(WIN_N + 1);

  logic [PW-1:0] phase_q, cur_phase;
  logic [VW-1:0] votes_q;
  logic [NW-1:0] null_q;
  logic          prev_null_q;
  logic          is_null, is_one;
  logic [VW-1:0] votes_now;

  assign is_null   = (sym == SYM_NULL);
  assign is_one    = (sym == SYM_ONE);
  assign cur_phase = prev_null_q ? '0 : phase_q;
  assign votes_now = votes_q + VW'(is_one);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= '0;
      votes_q     <= '0;
      null_q      <= '0;
      prev_null_q <= 1'b1;
      bit_vld     <= 1'b0;
      bit_val     <= 1'b0;
      gap         <= 1'b0;
    end else begin
      prev_null_q <= is_null;
      bit_vld     <= 1'b0;
      gap         <= is_null && (null_q == NW'(NULL_END - 1));
      if (is_null) begin
        phase_q <= '0;
        votes_q <= '0;
        if (null_q != NW'(NULL_END)) null_q <= null_q + 1'b1;
      end else begin
        null_q  <= '0;
        phase_q <= (cur_phase == PW'(OSR - 1)) ? cur_phase : cur_phase + 1'b1;
        if (cur_phase < PW'(WIN_LO)) begin
          votes_q <= '0;
        end else if (cur_phase < PW'(WIN_HI)) begin
          votes_q <= votes_now;
        end else if (cur_phase == PW'(WIN_HI)) begin
          bit_vld <= 1'b1;
          bit_val <= (votes_now >= VW'(MAJ));
          votes_q <= '0;
        end
      end
    end
  end

  a_r9_bit_from_active: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> ($past(sym) != SYM_NULL));
  a_r2_gap_after_null: assert property (@(posedge clk) disable iff (!rst_n)
    gap |-> ($past(sym) == SYM_NULL));
endmodule

// File: rtl/a429_word_framer.sv
module a429_word_framer
  import a429_rx_pkg::*;
#(
  parameter int unsigned SHORT_BITS = 25
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bit_vld,
  input  logic     bit_val,
  input  logic     gap,
  input  logic     len32,
  input  logic     sd_en,
  input  logic     sd_x,
  input  logic     sd_y,
  input  logic [1:0] half_ack,
  output logic     ready,
  output rx_word_t word
);
  localparam int unsigned CW    = $clog2(WORD_BITS + 2);
  localparam int unsigned SHIFT = WORD_BITS - SHORT_BITS;

  logic [WORD_BITS-1:0] sr_q, aligned;
  logic [CW-1:0]        cnt_q, target;
  logic [WORD_BITS-2:0] data_c, dmask;
  logic                 match, store;
  logic [1:0]           got_q, got_n;

  assign target  = len32 ? CW'(WORD_BITS) : CW'(SHORT_BITS);
  assign aligned = len32 ? sr_q : (sr_q >> SHIFT);
  assign dmask   = len32 ? '1 : (WORD_BITS-1)'((64'd1 << (SHORT_BITS - 1)) - 64'd1);
  assign data_c  = aligned[WORD_BITS-2:0] & dmask;
  assign match   = !sd_en || ((data_c[8] == sd_y) && (data_c[9] == sd_x));
  assign store   = gap && (cnt_q == target) && match;
  assign got_n   = got_q | half_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (gap) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (bit_vld) begin
      sr_q <= {bit_val, sr_q[WORD_BITS-1:1]};
      if (cnt_q != CW'(WORD_BITS + 1)) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      ready <= 1'b0;
      got_q <= '0;
    end else if (store) begin
      word.data   <= data_c;
      word.status <= ~(^aligned);
      ready       <= 1'b1;
      got_q       <= '0;
    end else if (ready) begin
      if (&got_n) begin
        ready <= 1'b0;
        got_q <= '0;
      end else begin
        got_q <= got_n;
      end
    end
  end

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(WORD_BITS + 1));
  a_r7_bad_len_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (gap && (cnt_q != target)) |=> $stable(word));
  a_r12_hold_mid_word: assert property (@(posedge clk) disable iff (!rst_n)
    !gap |=> $stable(word));
  a_r2_ready_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(gap));
endmodule

// File: rtl/dual_a429_rx.sv
module dual_a429_rx
  import a429_rx_pkg::*;
#(
  parameter int unsigned OSR         = 10,
  parameter int unsigned SHORT_BITS  = 25,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  line_a,
  input  logic [1:0]  line_b,
  input  logic        tx_a,
  input  logic        tx_b,
  input  logic        cfg_len32,
  input  logic        cfg_selftest_n,
  input  logic [1:0]  cfg_sd_en,
  input  logic [1:0]  cfg_sd_x,
  input  logic [1:0]  cfg_sd_y,
  input  logic        rd_sel,
  input  logic [1:0]  rd_en,
  output logic [15:0] rd_data,
  output logic [1:0]  ready
);
  localparam int unsigned NCH = 2;

  rx_word_t   words [NCH];
  logic [1:0] acks  [NCH];
  logic [NCH-1:0] drive;
  logic [HALF_BITS-1:0] halves [NCH][2];

  assign drive[0] = rd_en[0];
  assign drive[1] = rd_en[1] & ~rd_en[0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic in_a, in_b, bv, bval, gp;
    sym_e sym;

    if (c == 0) begin : g_true
      assign in_a = cfg_selftest_n ? line_a[c] : tx_a;
      assign in_b = cfg_selftest_n ? line_b[c] : tx_b;
    end else begin : g_inv
      assign in_a = cfg_selftest_n ? line_a[c] : tx_b;
      assign in_b = cfg_selftest_n ? line_b[c] : tx_a;
    end

    assign acks[c] = drive[c] ? (rd_sel ? 2'b10 : 2'b01) : 2'b00;
    assign halves[c][0] = {words[c].data[14:8], words[c].status, words[c].data[7:0]};
    assign halves[c][1] = words[c].data[WORD_BITS-2:HALF_BITS-1];

    a429_line_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk(clk), .rst_n(rst_n), .wire_a(in_a), .wire_b(in_b), .sym(sym));

    a429_bit_slicer #(.OSR(OSR)) u_slice (
      .clk(clk), .rst_n(rst_n), .sym(sym),
      .bit_vld(bv), .bit_val(bval), .gap(gp));

    a429_word_framer #(.SHORT_BITS(SHORT_BITS)) u_frame (
      .clk(clk), .rst_n(rst_n), .bit_vld(bv), .bit_val(bval), .gap(gp),
      .len32(cfg_len32), .sd_en(cfg_sd_en[c]), .sd_x(cfg_sd_x[c]),
      .sd_y(cfg_sd_y[c]), .half_ack(acks[c]),
      .ready(ready[c]), .word(words[c]));
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++)
      if (drive[c]) rd_data = halves[c][rd_sel];
  end

  a_r13_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en == 2'b00) |-> (rd_data == 16'h0000));
  a_r13_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drive));
  a_r8_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready[0]) |-> $past(rd_en[0]));
endmodule

// File: tb/dual_a429_rx_tb_top.sv
module dual_a429_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] line_a, line_b;
  logic tx_a, tx_b, cfg_len32, cfg_selftest_n, rd_sel;
  logic [1:0] cfg_sd_en, cfg_sd_x, cfg_sd_y, rd_en, ready;
  logic [15:0] rd_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_a429_rx dut_i (
    .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b),
    .tx_a(tx_a), .tx_b(tx_b), .cfg_len32(cfg_len32),
    .cfg_selftest_n(cfg_selftest_n), .cfg_sd_en(cfg_sd_en),
    .cfg_sd_x(cfg_sd_x), .cfg_sd_y(cfg_sd_y), .rd_sel(rd_sel),
    .rd_en(rd_en), .rd_data(rd_data), .ready(ready));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] w, input int len);
    logic [30:0] d;
    int ones = 0;
    for (int i = 0; i < len; i++) ones += int'(w[i]);
    d = (len == 25) ? {7'b0, w[23:0]} : w[30:0];
    return {d[30:15], d[14:8], (ones % 2 == 0), d[7:0]};
  endfunction

  function automatic logic [1:0] pair(input bit act, input logic v);
    if (!act) return 2'b00;
    return v ? 2'b10 : 2'b01;
  endfunction

  task automatic send(input logic [31:0] w0, input int n0, input logic [31:0] w1,
                      input int n1, input bit via_tx, input int flip_idx);
    int n = (n0 > n1) ? n0 : n1;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 10; k++) begin
        logic [1:0] p0, p1;
        @(negedge clk);
        p0 = pair((k < 5) && (i < n0), w0[i] ^ ((i == flip_idx) && (k == 2)));
        p1 = pair((k < 5) && (i < n1), w1[i]);
        if (via_tx) begin
          {tx_a, tx_b} = p0;
          {line_a[0], line_b[0]} = p1;
          {line_a[1], line_b[1]} = p1;
        end else begin
          {line_a[0], line_b[0]} = p0;
          {line_a[1], line_b[1]} = p1;
        end
      end
    end
    @(negedge clk);
    line_a = 0; line_b = 0; tx_a = 0; tx_b = 0;
    repeat (30) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] en, input logic sel, output logic [15:0] v);
    @(negedge clk);
    rd_en = en; rd_sel = sel;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic check_word(input int ch, input logic [31:0] w, input int len, input string tag);
    logic [15:0] h0, h1;
    logic [31:0] e = expect_word(w, len);
    rd(ch == 0 ? 2'b01 : 2'b10, 1'b0, h0);
    chk(h0 == e[15:0], {tag, " half0"}, {16'h0, h0}, {16'h0, e[15:0]});
    rd(ch == 0 ? 2'b01 : 2'b10, 1'b1, h1);
    chk(h1 == e[31:16], {tag, " half1"}, {16'h0, h1}, {16'h0, e[31:16]});
  endtask

  task automatic drain();
    logic [15:0] v;
    rd(2'b01, 0, v); rd(2'b01, 1, v); rd(2'b10, 0, v); rd(2'b10, 1, v);
  endtask

  task automatic t_reset();
    chk(ready == 2'b00, "R1 ready after reset", {30'h0, ready}, 0);
    chk(rd_data == 16'h0, "R1 idle bus", {16'h0, rd_data}, 0);
  endtask

  task automatic t_word32();
    logic [15:0] v;
    logic [31:0] w = 32'hA5C3_1E69;
    logic [31:0] e = expect_word(w, 32);
    send(w, 32, 0, 0, 0, -1);
    chk(ready == 2'b01, "R2 R11 ready ch0 only", {30'h0, ready}, 1);
    rd(2'b01, 0, v);
    chk(v == e[15:0], "R2 half0", {16'h0, v}, {16'h0, e[15:0]});
    chk(ready[0] == 1'b1, "R8 ready after one half", {31'h0, ready[0]}, 1);
    rd(2'b01, 1, v);
    chk(v == e[31:16], "R2 half1", {16'h0, v}, {16'h0, e[31:16]});
    chk(ready[0] == 1'b0, "R8 ready cleared", {31'h0, ready[0]}, 0);
  endtask

  task automatic t_parity();
    logic [15:0] v;
    send(32'h0000_0003, 32, 0, 0, 0, -1);
    rd(2'b01, 0, v);
    chk(v[8] == 1'b1, "R4 even ones status", {31'h0, v[8]}, 1);
    drain();
    send(32'h0000_0007, 32, 0, 0, 0, -1);
    rd(2'b01, 0, v);
    chk(v[8] == 1'b0, "R4 odd ones status", {31'h0, v[8]}, 0);
    drain();
  endtask

  task automatic t_len25();
    cfg_len32 = 0;
    send(32'h01AB_CDEF, 25, 0, 0, 0, -1);
    chk(ready[0] == 1'b1, "R3 25-bit accepted", {31'h0, ready[0]}, 1);
    check_word(0, 32'h01AB_CDEF, 25, "R3");
    send(32'h1234_5678, 32, 0, 0, 0, -1);
    chk(ready[0] == 1'b0, "R7 32 bits in 25 mode dropped", {31'h0, ready[0]}, 0);
    cfg_len32 = 1;
  endtask

  task automatic t_badcount();
    send(32'h5555_AAAA, 31, 0, 0, 0, -1);
    chk(ready[0] == 1'b0, "R7 short word dropped", {31'h0, ready[0]}, 0);
  endtask

  task automatic t_filter();
    logic [31:0] bad = 32'h0000_0100;
    logic [31:0] ok  = 32'h0000_0200;
    cfg_sd_en = 2'b01; cfg_sd_x = 2'b01; cfg_sd_y = 2'b00;
    send(bad, 32, bad, 32, 0, -1);
    chk(ready[0] == 1'b0, "R5 mismatch dropped", {31'h0, ready[0]}, 0);
    chk(ready[1] == 1'b1, "R6 filter off accepts", {31'h0, ready[1]}, 1);
    check_word(1, bad, 32, "R6");
    send(ok, 32, 0, 0, 0, -1);
    chk(ready[0] == 1'b1, "R5 match accepted", {31'h0, ready[0]}, 1);
    check_word(0, ok, 32, "R5");
    cfg_sd_en = 0; cfg_sd_x = 0; cfg_sd_y = 0;
  endtask

  task automatic t_vote();
    send(32'h0F0F_3C3C, 32, 0, 0, 0, 5);
    check_word(0, 32'h0F0F_3C3C, 32, "R9 flipped sample");
  endtask

  task automatic t_both();
    logic [15:0] v;
    logic [31:0] e = expect_word(32'hDEAD_BEEF, 32);
    send(32'hDEAD_BEEF, 32, 32'h1357_9BDF, 32, 0, -1);
    chk(ready == 2'b11, "R11 both ready", {30'h0, ready}, 3);
    rd(2'b11, 0, v);
    chk(v == e[15:0], "R13 ch0 priority", {16'h0, v}, {16'h0, e[15:0]});
    check_word(1, 32'h1357_9BDF, 32, "R11 ch1");
    chk(ready == 2'b01, "R13 ch1 read only clears ch1", {30'h0, ready}, 1);
    drain();
  endtask

  task automatic t_overwrite();
    logic [15:0] v;
    logic [31:0] ea = expect_word(32'h0246_8ACE, 32);
    send(32'h0246_8ACE, 32, 0, 0, 0, -1);
    fork
      send(32'hFDB9_7531, 32, 0, 0, 0, -1);
      begin
        repeat (150) @(negedge clk);
        rd(2'b01, 0, v);
        chk(v == ea[15:0], "R12 old word mid-reception", {16'h0, v}, {16'h0, ea[15:0]});
      end
    join
    chk(ready[0] == 1'b1, "R12 ready for new word", {31'h0, ready[0]}, 1);
    check_word(0, 32'hFDB9_7531, 32, "R12 new word");
  endtask

  task automatic t_loop();
    logic [31:0] w = 32'h8421_C3A5;
    cfg_selftest_n = 0;
    send(w, 32, 32'hFFFF_0000, 32, 1, -1);
    chk(ready == 2'b11, "R10 both looped", {30'h0, ready}, 3);
    check_word(0, w, 32, "R10 true");
    check_word(1, ~w, 32, "R10 inverted");
    cfg_selftest_n = 1;
  endtask

  initial begin
    rst_n = 0; line_a = 0; line_b = 0; tx_a = 0; tx_b = 0;
    cfg_len32 = 1; cfg_selftest_n = 1; cfg_sd_en = 0; cfg_sd_x = 0; cfg_sd_y = 0;
    rd_sel = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (40) @(negedge clk);
    t_reset();
    t_word32();
    t_parity();
    t_len25();
    t_badcount();
    t_filter();
    t_vote();
    t_both();
    t_overwrite();
    t_loop();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule